// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block brings a 16-bit DDR1 or DDR2 SDRAM out of power-up by stepping through a fixed command script after reset. A strap input, sampled once as reset is released, picks one of two scripts. Each step places a mode-register or extended-mode-register value on the data outputs, holds it for one cycle and then pulses exactly one bit of a one-hot command word toward the memory controller's command port. After each step the sequencer waits a number of clock cycles set by a parameter.

The DDR2 script is longer. It starts with extended-register-2 and -3 loads and a pad-select step, each followed by a short wait. It also enters and leaves off-chip driver calibration with a pair of extended-mode writes near the end. Both scripts finish the same way. The refresh word and a type-specific default DQS delay tap for both byte lanes are presented with a one-cycle load strobe, and then a done flag rises and stays high.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: `cmd_o` is zero or one-hot, and every nonzero value lasts a single cycle. The bit meanings are: bit 0 load mode register, bit 1 load extended mode register, bit 2 auto-refresh, bit 3 precharge-all, bit 4 load extended register 2, bit 5 load extended register 3.
- R2: With the strap low (DDR1) the commands are issued in this order: precharge-all; extended-mode load with value 0x000; mode load with 0x133; precharge-all; two auto-refreshes; mode load with 0x033.
- R3: With the strap high (DDR2) the commands are issued in this order: EMR2 load; EMR3 load; a pad-select step with no command, which drives `pad_ddr2_o` high from then on; precharge-all; EMR2; EMR3; extended-mode 0x402; mode 0x143; precharge-all; two auto-refreshes; mode 0x043; extended-mode 0x782; extended-mode 0x402. With the strap low, `pad_ddr2_o` stays 0.
- R4: `mode_o` and `emr_o` carry the value of the current step in the cycle before its strobe and in the strobe cycle. They keep that value until a later step changes it.
- R5: After a step with the standard wait, the next step's strobe comes exactly WAIT_STD+3 cycles later. The first strobe comes 3 cycles after the first clock edge with reset released.
- R6: The three early DDR2 steps use the short wait WAIT_STD/WAIT_DIV, which gives a step spacing of that value plus 3 cycles.
- R7: One standard step time after the last command, `cfg_load_o` pulses for one cycle. At that point `refresh_o` is the enable bit (bit 14) ORed with the interval 312, which is 0x4138. Both tap outputs are 0x20 for DDR1 and 0x10 for DDR2.
- R8: `done_o` rises in the cycle after `cfg_load_o` and stays high until reset. After that no command or load strobe occurs.
- R9: The strap is captured at the first clock edge after reset is released. Later changes to the strap have no effect on the script.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr2_strap_i | input | 1 | Memory type strap, 1 selects DDR2 |
| cmd_o | output | 6 | One-hot command strobe |
| mode_o | output | 13 | Mode register value |
| emr_o | output | 13 | Extended mode register value |
| pad_ddr2_o | output | 1 | DDR2 pad select |
| refresh_o | output | 16 | Refresh enable and interval word |
| tap_dqs0_o | output | 6 | Default delay tap, lane 0 |
| tap_dqs1_o | output | 6 | Default delay tap, lane 1 |
| cfg_load_o | output | 1 | One-cycle strobe for refresh and tap values |
| done_o | output | 1 | Initialization complete |

## Verification
The bench plays both complete scripts and predicts every step from its own table: the strobe cycle, the command bit and the register values one cycle before and during the strobe. A misordered step, a swapped bit or a wrong value therefore shows up as a miscompare. Running both strap values separates the DDR1 and DDR2 scripts and their short and standard waits, and it catches a pad-select or tap value that leaks from one type into the other. Two more runs flip the strap just after reset is released, which separates one-time sampling from continuous sampling. Long idle stretches after done confirm that no further strobes occur.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam int CMD_W = 6;
  localparam int MRV_W = 13;
  localparam int IDX_W = 4;

  localparam int CB_MRS  = 0;
  localparam int CB_EMRS = 1;
  localparam int CB_REF  = 2;
  localparam int CB_PRE  = 3;
  localparam int CB_EMR2 = 4;
  localparam int CB_EMR3 = 5;

  typedef enum logic [1:0] {SK_CMD, SK_PAD, SK_FINAL} step_kind_e;

  typedef struct packed {
    step_kind_e         kind;
    logic [CMD_W-1:0]   cmd;
    logic               set_mode;
    logic [MRV_W-1:0]   mode;
    logic               set_emr;
    logic [MRV_W-1:0]   emr;
    logic               short_wait;
  } step_t;

  function automatic step_t blank_step();
    step_t s;
    s = '0;
    s.kind = SK_CMD;
    return s;
  endfunction

  function automatic step_t bare_cmd(input int bitpos, input logic sh);
    step_t s;
    s = blank_step();
    s.cmd[bitpos] = 1'b1;
    s.short_wait = sh;
    return s;
  endfunction

  function automatic step_t mode_cmd(input logic [MRV_W-1:0] v);
    step_t s;
    s = bare_cmd(CB_MRS, 1'b0);
    s.set_mode = 1'b1;
    s.mode = v;
    return s;
  endfunction

  function automatic step_t ext_cmd(input logic [MRV_W-1:0] v);
    step_t s;
    s = bare_cmd(CB_EMRS, 1'b0);
    s.set_emr = 1'b1;
    s.emr = v;
    return s;
  endfunction

  function automatic step_t final_step();
    step_t s;
    s = blank_step();
    s.kind = SK_FINAL;
    return s;
  endfunction

  function automatic step_t ddr1_step(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return bare_cmd(CB_PRE, 1'b0);
      4'd1:    return ext_cmd(13'h000);
      4'd2:    return mode_cmd(13'h133);
      4'd3:    return bare_cmd(CB_PRE, 1'b0);
      4'd4:    return bare_cmd(CB_REF, 1'b0);
      4'd5:    return bare_cmd(CB_REF, 1'b0);
      4'd6:    return mode_cmd(13'h033);
      default: return final_step();
    endcase
  endfunction

  function automatic step_t ddr2_step(input logic [IDX_W-1:0] idx);
    step_t s;
    case (idx)
      4'd0:  return bare_cmd(CB_EMR2, 1'b1);
      4'd1:  return bare_cmd(CB_EMR3, 1'b1);
      4'd2: begin
        s = blank_step();
        s.kind = SK_PAD;
        s.short_wait = 1'b1;
        return s;
      end
      4'd3:    return bare_cmd(CB_PRE, 1'b0);
      4'd4:    return bare_cmd(CB_EMR2, 1'b0);
      4'd5:    return bare_cmd(CB_EMR3, 1'b0);
      4'd6:    return ext_cmd(13'h402);
      4'd7:    return mode_cmd(13'h143);
      4'd8:    return bare_cmd(CB_PRE, 1'b0);
      4'd9:    return bare_cmd(CB_REF, 1'b0);
      4'd10:   return bare_cmd(CB_REF, 1'b0);
      4'd11:   return mode_cmd(13'h043);
      4'd12:   return ext_cmd(13'h782);
      4'd13:   return ext_cmd(13'h402);
      default: return final_step();
    endcase
  endfunction

  function automatic step_t script_step(input logic ddr2, input logic [IDX_W-1:0] idx);
    return ddr2 ? ddr2_step(idx) : ddr1_step(idx);
  endfunction

  function automatic logic [31:0] refresh_word(input int interval, input int en_bit,
                                               input int ival_w);
    logic [31:0] w;
    w = 32'(interval) & ((32'd1 << ival_w) - 32'd1);
    w[en_bit] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/ddr_seq_timer.sv
module ddr_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] span_m1,
  output logic          expired
);
  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= span_m1;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign expired = busy && (cnt == '0);

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !start) |=> (busy && cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/ddr_seq_fsm.sv
module ddr_seq_fsm
  import ddr_seq_pkg::*;
#(
  parameter int WAIT_STD   = 100,
  parameter int WAIT_SHORT = 10,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_i,
  input  logic          tmr_expired,
  output step_t         step_o,
  output logic          ddr2_o,
  output logic          load_o,
  output logic          fire_o,
  output logic          done_o,
  output logic          tmr_start_o,
  output logic [CW-1:0] tmr_span_o
);
  typedef enum logic [2:0] {PH_START, PH_LOAD, PH_HOLD, PH_FIRE, PH_WAIT, PH_DONE} phase_e;

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic             strap_q;

  assign step_o = script_step(strap_q, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_START;
      idx     <= '0;
      strap_q <= 1'b0;
    end else begin
      case (phase)
        PH_START: begin
          strap_q <= strap_i;
          idx     <= '0;
          phase   <= PH_LOAD;
        end
        PH_LOAD: phase <= PH_HOLD;
        PH_HOLD: phase <= PH_FIRE;
        PH_FIRE: phase <= (step_o.kind == SK_FINAL) ? PH_DONE : PH_WAIT;
        PH_WAIT: if (tmr_expired) begin
          idx   <= idx + IDX_W'(1);
          phase <= PH_LOAD;
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  assign ddr2_o      = strap_q;
  assign load_o      = (phase == PH_LOAD);
  assign fire_o      = (phase == PH_FIRE);
  assign done_o      = (phase == PH_DONE);
  assign tmr_start_o = fire_o && (step_o.kind != SK_FINAL);
  assign tmr_span_o  = step_o.short_wait ? CW'(WAIT_SHORT - 1) : CW'(WAIT_STD - 1);

  assert_strap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_START) |=> $stable(strap_q));

  assert_wait_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && tmr_expired) |=> (phase == PH_LOAD));

endmodule

// File: rtl/ddr_seq_outregs.sv
module ddr_seq_outregs
  import ddr_seq_pkg::*;
#(
  parameter int REF_W        = 16,
  parameter int REF_IVAL_W   = 10,
  parameter int REF_EN_BIT   = 14,
  parameter int REF_INTERVAL = 312,
  parameter int TAP_W        = 6,
  parameter int TAP_DDR1     = 32,
  parameter int TAP_DDR2     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             ddr2_i,
  input  step_kind_e       kind_i,
  input  logic             set_mode_i,
  input  logic [MRV_W-1:0] mode_i,
  input  logic             set_emr_i,
  input  logic [MRV_W-1:0] emr_i,
  output logic [MRV_W-1:0] mode_o,
  output logic [MRV_W-1:0] emr_o,
  output logic             pad_o,
  output logic [REF_W-1:0] refresh_o,
  output logic [TAP_W-1:0] tap0_o,
  output logic [TAP_W-1:0] tap1_o
);
  localparam logic [31:0] REF_FULL = refresh_word(REF_INTERVAL, REF_EN_BIT, REF_IVAL_W);
  localparam logic [REF_W-1:0] REF_VAL = REF_FULL[REF_W-1:0];

  logic [TAP_W-1:0] tap_pick;
  assign tap_pick = ddr2_i ? TAP_W'(TAP_DDR2) : TAP_W'(TAP_DDR1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o    <= '0;
      emr_o     <= '0;
      pad_o     <= 1'b0;
      refresh_o <= '0;
      tap0_o    <= '0;
      tap1_o    <= '0;
    end else if (load_i) begin
      if (set_mode_i)         mode_o <= mode_i;
      if (set_emr_i)          emr_o  <= emr_i;
      if (kind_i == SK_PAD)   pad_o  <= 1'b1;
      if (kind_i == SK_FINAL) begin
        refresh_o <= REF_VAL;
        tap0_o    <= tap_pick;
        tap1_o    <= tap_pick;
      end
    end
  end

  assert_pad_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_o |=> pad_o);

  assert_pad_ddr2_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_o |-> ddr2_i);

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq #(
  parameter int WAIT_STD     = 100,
  parameter int WAIT_DIV     = 10,
  parameter int REF_W        = 16,
  parameter int REF_IVAL_W   = 10,
  parameter int REF_EN_BIT   = 14,
  parameter int REF_INTERVAL = 312,
  parameter int TAP_W        = 6,
  parameter int TAP_DDR1     = 32,
  parameter int TAP_DDR2     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr2_strap_i,
  output logic [5:0]        cmd_o,
  output logic [12:0]       mode_o,
  output logic [12:0]       emr_o,
  output logic              pad_ddr2_o,
  output logic [REF_W-1:0]  refresh_o,
  output logic [TAP_W-1:0]  tap_dqs0_o,
  output logic [TAP_W-1:0]  tap_dqs1_o,
  output logic              cfg_load_o,
  output logic              done_o
);
  import ddr_seq_pkg::*;

  localparam int WAIT_SHORT = (WAIT_STD / WAIT_DIV < 1) ? 1 : WAIT_STD / WAIT_DIV;
  localparam int CW         = $clog2(WAIT_STD + 1);

  step_t         cur_step;
  logic          ddr2_q;
  logic          load_w, fire_w, done_w;
  logic          tmr_start, tmr_expired;
  logic [CW-1:0] tmr_span;

  ddr_seq_fsm #(.WAIT_STD(WAIT_STD), .WAIT_SHORT(WAIT_SHORT), .CW(CW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (ddr2_strap_i),
    .tmr_expired (tmr_expired),
    .step_o      (cur_step),
    .ddr2_o      (ddr2_q),
    .load_o      (load_w),
    .fire_o      (fire_w),
    .done_o      (done_w),
    .tmr_start_o (tmr_start),
    .tmr_span_o  (tmr_span)
  );

  ddr_seq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .span_m1 (tmr_span),
    .expired (tmr_expired)
  );

  ddr_seq_outregs #(
    .REF_W(REF_W), .REF_IVAL_W(REF_IVAL_W), .REF_EN_BIT(REF_EN_BIT),
    .REF_INTERVAL(REF_INTERVAL), .TAP_W(TAP_W),
    .TAP_DDR1(TAP_DDR1), .TAP_DDR2(TAP_DDR2)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .ddr2_i     (ddr2_q),
    .kind_i     (cur_step.kind),
    .set_mode_i (cur_step.set_mode),
    .mode_i     (cur_step.mode),
    .set_emr_i  (cur_step.set_emr),
    .emr_i      (cur_step.emr),
    .mode_o     (mode_o),
    .emr_o      (emr_o),
    .pad_o      (pad_ddr2_o),
    .refresh_o  (refresh_o),
    .tap0_o     (tap_dqs0_o),
    .tap1_o     (tap_dqs1_o)
  );

  assign cmd_o      = (fire_w && cur_step.kind == SK_CMD) ? cur_step.cmd : '0;
  assign cfg_load_o = fire_w && (cur_step.kind == SK_FINAL);
  assign done_o     = done_w;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_o));

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != '0) |=> (cmd_o == '0));

  assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != '0) |-> ($stable(mode_o) && $stable(emr_o)));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd_o == '0 && !cfg_load_o));

  assert_cfg_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_o |=> done_o);

endmodule

// File: tb/sim_ddr_pwrup_seq.sv
`timescale 1ns/1ps
module sim_ddr_pwrup_seq;
  localparam int WSTD = 100;
  localparam int WSH  = WSTD / 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [5:0]  cmd_o;
  logic [12:0] mode_o, emr_o;
  logic        pad_o, cfg_o, done_o;
  logic [15:0] ref_o;
  logic [5:0]  tap0, tap1;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ddr_pwrup_seq u0 (
    .clk(clk), .rst_n(rst_n), .ddr2_strap_i(strap),
    .cmd_o(cmd_o), .mode_o(mode_o), .emr_o(emr_o), .pad_ddr2_o(pad_o),
    .refresh_o(ref_o), .tap_dqs0_o(tap0), .tap_dqs1_o(tap1),
    .cfg_load_o(cfg_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec = nvec + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 command, 1 pad step, 2 final; cb = command bit; m/e = -1 keeps value
  task automatic step_exp(input bit d2, input int j, output int kind, output int cb,
                          output int m, output int e, output bit sh);
    kind = 0; cb = 0; m = -1; e = -1; sh = 0;
    if (!d2) begin
      case (j)
        0, 3: cb = 3;
        1: begin cb = 1; e = 'h000; end
        2: begin cb = 0; m = 'h133; end
        4, 5: cb = 2;
        6: begin cb = 0; m = 'h033; end
        default: kind = 2;
      endcase
    end else begin
      case (j)
        0: begin cb = 4; sh = 1; end
        1: begin cb = 5; sh = 1; end
        2: begin kind = 1; sh = 1; end
        3, 8: cb = 3;
        4: cb = 4;
        5: cb = 5;
        6, 13: begin cb = 1; e = 'h402; end
        7: begin cb = 0; m = 'h143; end
        9, 10: cb = 2;
        11: begin cb = 0; m = 'h043; end
        12: begin cb = 1; e = 'h782; end
        default: kind = 2;
      endcase
    end
  endtask

  task automatic run(input bit d2, input bit flip);
    int    t, ft, kind, cb, m, e, cm, ce, nsteps;
    bit    sh, prev_sh, pexp;
    string sq;
    sq = flip ? "R9" : (d2 ? "R3" : "R2");
    nsteps = d2 ? 15 : 8;
    @(negedge clk);
    rst_n = 1'b0;
    strap = d2;
    repeat (3) @(negedge clk);
    chk(cmd_o == 0 && mode_o == 0 && emr_o == 0 && !pad_o && ref_o == 0 &&
        tap0 == 0 && tap1 == 0 && !cfg_o && !done_o, "R10", "reset outputs",
        {cmd_o, mode_o, emr_o}, 0);
    rst_n = 1'b1;
    t = 0;
    @(posedge clk);
    if (flip) #1 strap = ~d2;
    ft = 3; cm = 0; ce = 0; pexp = 0; prev_sh = 0;
    for (int j = 0; j < nsteps; j++) begin
      step_exp(d2, j, kind, cb, m, e, sh);
      if (m >= 0) cm = m;
      if (e >= 0) ce = e;
      if (kind == 1) pexp = 1;
      while (t < ft) begin
        @(negedge clk);
        t++;
        if (t < ft && cmd_o != 0)
          chk(0, "R1", "unexpected strobe", cmd_o, 0);
        if (t == ft - 1)
          chk(mode_o == 13'(cm) && emr_o == 13'(ce), "R4", "data before strobe",
              {mode_o, emr_o}, {13'(cm), 13'(ce)});
      end
      if (kind == 0) begin
        chk(cmd_o == (6'd1 << cb), prev_sh ? "R6" : "R5", "strobe time",
            cmd_o, 6'd1 << cb);
        chk(cmd_o == (6'd1 << cb), sq, "command bit", cmd_o, 6'd1 << cb);
        chk(mode_o == 13'(cm) && emr_o == 13'(ce), sq, "mode/emr at strobe",
            {mode_o, emr_o}, {13'(cm), 13'(ce)});
        chk(pad_o == pexp, "R3", "pad select", pad_o, pexp);
      end else if (kind == 1) begin
        chk(cmd_o == 0 && pad_o, "R3", "pad step", {cmd_o, pad_o}, 1);
      end else begin
        chk(cfg_o, "R7", "cfg load time", cfg_o, 1);
        chk(ref_o == 16'h4138, "R7", "refresh word", ref_o, 16'h4138);
        chk(tap0 == (d2 ? 6'h10 : 6'h20) && tap1 == tap0, "R7", "taps",
            {tap0, tap1}, d2 ? 12'h410 : 12'h820);
        chk(!done_o, "R8", "done before load", done_o, 0);
      end
      prev_sh = sh;
      ft = ft + (sh ? WSH : WSTD) + 3;
    end
    @(negedge clk);
    chk(done_o && !cfg_o, "R8", "done after load", {done_o, cfg_o}, 2);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!done_o || cmd_o != 0 || cfg_o)
        chk(0, "R8", "quiet after done", {done_o, cmd_o, cfg_o}, 128);
    end
    chk(done_o && pad_o == d2, flip ? "R9" : "R8", "final state",
        {done_o, pad_o}, {1'b1, d2});
  endtask

  initial begin
    run(1'b0, 1'b0);
    run(1'b1, 1'b0);
    run(1'b0, 1'b1);
    run(1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule